// File: doc/BRIEF.md
# Ethernet DMA Channel Status Sequencer

This block is the control and status core for the receive and transmit bus-master DMA channels of an Ethernet MAC. A register interface hands it single-cycle command strobes: receive enable, receive channel reset, transmit enable, transmit disable and manual transfer. The DMA engine and the FIFOs return handshakes: transmit halted, plus a serviced flag and an empty flag for each FIFO. The block produces a read-only status word and the receive queue endpoint and enqueue-count values.

The receive enable command acts once. The first enable after a reset or a receive channel reset starts a four-cycle initialization. That sequence clears both receive enqueue counters, then computes the end address of the receive descriptor queue, then computes the end address of the receive status queue, and then finishes. Receive-active goes high only once that sequence is done.

The transmit-active flag falls only after a disable command has been seen and the engine has reported that it halted. A manual transfer command starts a sweep that visits each FIFO in index order. The transfer-pending flag and a queue index field show the sweep while it runs.

Top module: `eth_dma_status_seq`

## Requirements
- R1: After reset, the status word, both queue end addresses and both enqueue counters read zero.
- R2: Receive-active rises on exactly the fifth rising clock edge counting the edge that samples the first receive enable. It is low on the four edges before that.
- R3: Initialization clears both enqueue counters. It sets the descriptor queue end to descriptor base plus length, and the status queue end to status base plus length, both modulo 2^ADDR_W. While receive-active is high, each enqueue pulse adds one to its counter.
- R4: A receive enable that arrives while initialization is running, or after receive-active is set, has no effect: the timing does not change and the counters are not cleared again.
- R5: A receive channel reset clears receive-active on the next edge and aborts an initialization in progress. The next receive enable starts a full initialization again.
- R6: A transmit enable sets transmit-active on the next edge. Transmit-active then stays high until a transmit disable has been taken and, on a later edge, the halted input is seen high, and it clears on that edge. A halted input without a preceding disable has no effect.
- R7: A manual transfer command sets transfer-pending on the next edge and sets the queue index to 0. On each edge where FIFO[index] is serviced or empty, the index advances by one. After the last FIFO is visited, pending clears and the index returns to 0. Pending therefore lasts NUM_FIFO cycles plus the cycles spent waiting, and the index is 0 whenever pending is low.
- R8: Status word layout: bit 0 is receive-active, bit 1 is transmit-active, bit 2 is transfer-pending, and bits 11:4 hold the queue index. Bit 3 and bits 31:12 always read zero.
- R9: A manual transfer command while a sweep is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rx_en | input | 1 | Receive enable strobe |
| cmd_rx_rst | input | 1 | Receive channel reset strobe |
| cmd_tx_en | input | 1 | Transmit enable strobe |
| cmd_tx_dis | input | 1 | Transmit disable strobe |
| cmd_man_xfer | input | 1 | Manual transfer strobe |
| tx_halted | input | 1 | DMA engine reports transmit transfers halted |
| fifo_serviced | input | NUM_FIFO | FIFO has been serviced by a DMA transfer |
| fifo_empty | input | NUM_FIFO | FIFO is empty, so it counts as inactive |
| rxd_enq | input | 1 | Descriptor enqueue pulse |
| rxs_enq | input | 1 | Status enqueue pulse |
| rxd_base | input | ADDR_W | Descriptor queue base address |
| rxd_len | input | ADDR_W | Descriptor queue length |
| rxs_base | input | ADDR_W | Status queue base address |
| rxs_len | input | ADDR_W | Status queue length |
| status | output | 32 | Read-only status word |
| rxd_end | output | ADDR_W | Descriptor queue end address |
| rxs_end | output | ADDR_W | Status queue end address |
| rxd_cnt | output | CNT_W | Descriptor enqueue counter |
| rxs_cnt | output | CNT_W | Status enqueue counter |

## Verification
The sweep is exercised with one FIFO held unready for 0, 1 or 2 cycles, for every FIFO index in turn. Odd FIFOs are released through the serviced flag and even ones through the empty flag, and a second strobe is issued mid-sweep. This tells apart a stuck index, a skipped FIFO, a wrongly accepted restart and an OR that misses either flag. Receive initialization is run with base and length pairs that wrap the address width. It is also run with a repeated enable during the sequence, with an enable after activation and with a channel reset mid-sequence, which separates correct first-enable arming from re-initialization and latency errors. The transmit channel sees halted both with and without a preceding disable.

// File: rtl/edss_pkg.sv
package edss_pkg;

    localparam int STATUS_W    = 32;
    localparam int QID_FIELD_W = 8;

    typedef enum logic [2:0] {
        INIT_IDLE,
        INIT_CLR,
        INIT_DEND,
        INIT_SEND,
        INIT_FIN
    } init_state_t;

    // status word: bit0 rx active, bit1 tx active, bit2 pending, [11:4] queue index
    typedef struct packed {
        logic [19:0]            rsvd_hi;
        logic [QID_FIELD_W-1:0] qid;
        logic                   rsvd3;
        logic                   pend;
        logic                   tx_act;
        logic                   rx_act;
    } status_t;

    function automatic status_t pack_status(input logic rx, input logic tx,
                                            input logic pend,
                                            input logic [QID_FIELD_W-1:0] qid);
        status_t s;
        s         = '0;
        s.rx_act  = rx;
        s.tx_act  = tx;
        s.pend    = pend;
        s.qid     = qid;
        return s;
    endfunction

endpackage

// File: rtl/edss_rx_init.sv
module edss_rx_init
    import edss_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rx_rst,
    input  logic              rxd_enq,
    input  logic              rxs_enq,
    input  logic [ADDR_W-1:0] rxd_base,
    input  logic [ADDR_W-1:0] rxd_len,
    input  logic [ADDR_W-1:0] rxs_base,
    input  logic [ADDR_W-1:0] rxs_len,
    output logic              rx_act,
    output logic [ADDR_W-1:0] rxd_end,
    output logic [ADDR_W-1:0] rxs_end,
    output logic [CNT_W-1:0]  rxd_cnt,
    output logic [CNT_W-1:0]  rxs_cnt
);
    init_state_t state;
    logic        armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= INIT_IDLE;
            armed   <= 1'b1;
            rx_act  <= 1'b0;
            rxd_end <= '0;
            rxs_end <= '0;
            rxd_cnt <= '0;
            rxs_cnt <= '0;
        end else if (rx_rst) begin
            state  <= INIT_IDLE;
            armed  <= 1'b1;
            rx_act <= 1'b0;
        end else begin
            unique case (state)
                INIT_IDLE: begin
                    if (rx_en && armed) begin
                        state <= INIT_CLR;
                        armed <= 1'b0;
                    end
                    if (rx_act && rxd_enq) rxd_cnt <= rxd_cnt + 1'b1;
                    if (rx_act && rxs_enq) rxs_cnt <= rxs_cnt + 1'b1;
                end
                INIT_CLR: begin
                    rxd_cnt <= '0;
                    rxs_cnt <= '0;
                    state   <= INIT_DEND;
                end
                INIT_DEND: begin
                    rxd_end <= rxd_base + rxd_len;
                    state   <= INIT_SEND;
                end
                INIT_SEND: begin
                    rxs_end <= rxs_base + rxs_len;
                    state   <= INIT_FIN;
                end
                INIT_FIN: begin
                    rx_act <= 1'b1;
                    state  <= INIT_IDLE;
                end
                default: state <= INIT_IDLE;
            endcase
        end
    end

    AST_ACT_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_act) |-> (rxd_cnt == '0 && rxs_cnt == '0)); // R3
    AST_ACT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_act) |-> $past(rx_en, 5)); // R2
    AST_RST_DROPS_ACT: assert property (@(posedge clk) disable iff (rst)
        rx_rst |=> !rx_act); // R5

endmodule

// File: rtl/edss_tx_track.sv
module edss_tx_track (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_dis,
    input  logic tx_halted,
    output logic tx_act
);
    logic dis_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_act   <= 1'b0;
            dis_pend <= 1'b0;
        end else if (dis_pend) begin
            if (tx_halted) begin
                tx_act   <= 1'b0;
                dis_pend <= 1'b0;
            end
        end else if (tx_dis && tx_act) begin
            dis_pend <= 1'b1;
        end else if (tx_en) begin
            tx_act <= 1'b1;
        end
    end

    AST_TX_FALL_NEEDS_HALT: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_act) |-> $past(tx_halted)); // R6
    AST_TX_EN_SETS: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !tx_act && !tx_dis) |=> tx_act); // R6

endmodule

// File: rtl/edss_fifo_sweep.sv
module edss_fifo_sweep #(
    parameter int NUM_FIFO = 4,
    localparam int QID_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NUM_FIFO-1:0] serviced,
    input  logic [NUM_FIFO-1:0] empty,
    output logic                pend,
    output logic [QID_W-1:0]    qid
);
    localparam logic [QID_W-1:0] LAST_Q = QID_W'(NUM_FIFO - 1);

    logic [NUM_FIFO-1:0] done_vec;
    logic                cur_done;

    assign done_vec = serviced | empty;
    assign cur_done = done_vec[qid];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            qid  <= '0;
        end else if (!pend) begin
            if (start) begin
                pend <= 1'b1;
                qid  <= '0;
            end
        end else if (cur_done) begin
            if (qid == LAST_Q) begin
                pend <= 1'b0;
                qid  <= '0;
            end else begin
                qid <= qid + 1'b1;
            end
        end
    end

    AST_QID_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pend |-> (qid == '0)); // R7
    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (start && !pend) |=> pend); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (pend && start && !cur_done) |=> (qid == $past(qid))); // R9

endmodule

// File: rtl/eth_dma_status_seq.sv
module eth_dma_status_seq
    import edss_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_rx_en,
    input  logic                cmd_rx_rst,
    input  logic                cmd_tx_en,
    input  logic                cmd_tx_dis,
    input  logic                cmd_man_xfer,
    input  logic                tx_halted,
    input  logic [NUM_FIFO-1:0] fifo_serviced,
    input  logic [NUM_FIFO-1:0] fifo_empty,
    input  logic                rxd_enq,
    input  logic                rxs_enq,
    input  logic [ADDR_W-1:0]   rxd_base,
    input  logic [ADDR_W-1:0]   rxd_len,
    input  logic [ADDR_W-1:0]   rxs_base,
    input  logic [ADDR_W-1:0]   rxs_len,
    output logic [31:0]         status,
    output logic [ADDR_W-1:0]   rxd_end,
    output logic [ADDR_W-1:0]   rxs_end,
    output logic [CNT_W-1:0]    rxd_cnt,
    output logic [CNT_W-1:0]    rxs_cnt
);
    localparam int QID_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1;

    logic             rx_act;
    logic             tx_act;
    logic             sw_pend;
    logic [QID_W-1:0] sw_qid;
    status_t          stat_s;

    edss_rx_init #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .rx_en(cmd_rx_en), .rx_rst(cmd_rx_rst),
        .rxd_enq(rxd_enq), .rxs_enq(rxs_enq),
        .rxd_base(rxd_base), .rxd_len(rxd_len),
        .rxs_base(rxs_base), .rxs_len(rxs_len),
        .rx_act(rx_act), .rxd_end(rxd_end), .rxs_end(rxs_end),
        .rxd_cnt(rxd_cnt), .rxs_cnt(rxs_cnt)
    );

    edss_tx_track u_tx (
        .clk(clk), .rst(rst), .tx_en(cmd_tx_en), .tx_dis(cmd_tx_dis),
        .tx_halted(tx_halted), .tx_act(tx_act)
    );

    edss_fifo_sweep #(.NUM_FIFO(NUM_FIFO)) u_sweep (
        .clk(clk), .rst(rst), .start(cmd_man_xfer),
        .serviced(fifo_serviced), .empty(fifo_empty),
        .pend(sw_pend), .qid(sw_qid)
    );

    assign stat_s = pack_status(rx_act, tx_act, sw_pend, QID_FIELD_W'(sw_qid));
    assign status = stat_s;

    AST_RX_ACT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !cmd_rx_rst) |=> status[0]); // R4

endmodule

// File: tb/test_eth_dma_status_seq.sv
module test_eth_dma_status_seq;
    localparam int NF = 4;
    localparam int AW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_rx_en = 0, cmd_rx_rst = 0, cmd_tx_en = 0, cmd_tx_dis = 0, cmd_man_xfer = 0;
    logic          tx_halted = 0;
    logic [NF-1:0] fifo_serviced = '0, fifo_empty = '0;
    logic          rxd_enq = 0, rxs_enq = 0;
    logic [AW-1:0] rxd_base = '0, rxd_len = '0, rxs_base = '0, rxs_len = '0;
    logic [31:0]   status;
    logic [AW-1:0] rxd_end, rxs_end;
    logic [CW-1:0] rxd_cnt, rxs_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    eth_dma_status_seq #(.NUM_FIFO(NF), .ADDR_W(AW), .CNT_W(CW)) i_eth_dma_status_seq (
        .clk(clk), .rst(rst), .cmd_rx_en(cmd_rx_en), .cmd_rx_rst(cmd_rx_rst),
        .cmd_tx_en(cmd_tx_en), .cmd_tx_dis(cmd_tx_dis), .cmd_man_xfer(cmd_man_xfer),
        .tx_halted(tx_halted), .fifo_serviced(fifo_serviced), .fifo_empty(fifo_empty),
        .rxd_enq(rxd_enq), .rxs_enq(rxs_enq), .rxd_base(rxd_base), .rxd_len(rxd_len),
        .rxs_base(rxs_base), .rxs_len(rxs_len), .status(status), .rxd_end(rxd_end),
        .rxs_end(rxs_end), .rxd_cnt(rxd_cnt), .rxs_cnt(rxs_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    // enable, then return after the edge on which rx active should rise
    task automatic rx_enable_and_wait(input string tag);
        cmd_rx_en = 1;
        cyc();
        cmd_rx_en = 0;
        for (int k = 2; k <= 4; k++) begin
            cyc();
            chk({tag, " R2 low before fifth edge"}, {31'd0, status[0]}, 32'd0);
        end
        cyc();
        chk({tag, " R2 high on fifth edge"}, {31'd0, status[0]}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [AW-1:0] eb, el, sb, sl;
        repeat (3) cyc();
        rst = 0;
        cyc();
        chk("R1 status", status, 32'd0);
        chk("R1 rxd_end", rxd_end, 32'd0);
        chk("R1 rxs_end", rxs_end, 32'd0);
        chk("R1 counters", {16'd0, rxd_cnt, rxs_cnt}, 32'd0);

        // R7 / R9 / R8: sweep with one FIFO held back K cycles
        for (int j = 0; j < NF; j++) begin
            for (int kw = 0; kw < 3; kw++) begin
                logic          mp;
                int            mq, waited, mism, pcyc;
                logic [NF-1:0] r;
                logic          blocked, strobe;
                mp = 0; mq = 0; waited = 0; mism = 0; pcyc = 0;
                for (int c = 0; c < NF + kw + 4; c++) begin
                    blocked = mp && (mq == j) && (waited < kw);
                    r = '1;
                    if (blocked) r[j] = 1'b0;
                    for (int b = 0; b < NF; b++) begin
                        fifo_empty[b]    = r[b] && (b % 2 == 0);
                        fifo_serviced[b] = r[b] && (b % 2 == 1);
                    end
                    strobe = (c == 0) || (c == 2);
                    cmd_man_xfer = strobe;
                    cyc();
                    cmd_man_xfer = 0;
                    if (!mp) begin
                        if (strobe) begin mp = 1; mq = 0; end
                    end else if (r[mq]) begin
                        if (mq == NF - 1) begin mp = 0; mq = 0; end
                        else mq++;
                    end else if (blocked) begin
                        waited++;
                    end
                    if (status[2]) pcyc++;
                    if (status !== ((32'(mq) << 4) | (32'(mp) << 2))) mism++;
                end
                chk($sformatf("R7 R8 R9 sweep j=%0d wait=%0d status mismatches", j, kw), mism, 0);
                chk($sformatf("R7 R9 sweep j=%0d wait=%0d pending length", j, kw), pcyc, NF + kw);
            end
        end
        fifo_empty = '0;
        fifo_serviced = '0;

        // R3 endpoints across wrapping values, each run re-armed by channel reset (R5)
        for (int i = 0; i < 4; i++) begin
            eb = 32'hFFFF_FF00 + 32'(i * 64);
            el = 32'h0000_0180 - 32'(i * 16);
            sb = 32'h1000_0000 * 32'(i + 1);
            sl = 32'hF000_0000 + 32'(i * 3);
            rxd_base = eb; rxd_len = el; rxs_base = sb; rxs_len = sl;
            cmd_rx_rst = 1;
            cyc();
            cmd_rx_rst = 0;
            chk("R5 reset clears rx active", {31'd0, status[0]}, 32'd0);
            rx_enable_and_wait("endpoints");
            chk("R3 descriptor end", rxd_end, eb + el);
            chk("R3 status end", rxs_end, sb + sl);
        end

        // R3 counting, R4 later enable no reinit
        rxd_enq = 1; rxs_enq = 1;
        cyc();
        cyc();
        rxs_enq = 0;
        cyc();
        rxd_enq = 0;
        chk("R3 descriptor count", rxd_cnt, 32'd3);
        chk("R3 status count", rxs_cnt, 32'd2);
        cmd_rx_en = 1;
        cyc();
        cmd_rx_en = 0;
        repeat (6) cyc();
        chk("R4 enable after active keeps count", {16'd0, rxd_cnt, rxs_cnt}, {16'd0, 8'd3, 8'd2});
        chk("R4 enable after active keeps rx active", {31'd0, status[0]}, 32'd1);

        // R5 re-arm clears counters on next init
        cmd_rx_rst = 1;
        cyc();
        cmd_rx_rst = 0;
        chk("R5 reset drops active", {31'd0, status[0]}, 32'd0);
        rx_enable_and_wait("rearm");
        chk("R5 rearmed init clears counts", {16'd0, rxd_cnt, rxs_cnt}, 32'd0);

        // R4 enable during init ignored
        cmd_rx_rst = 1;
        cyc();
        cmd_rx_rst = 0;
        cmd_rx_en = 1;
        cyc();
        cmd_rx_en = 0;
        cyc();
        cmd_rx_en = 1;
        cyc();
        cmd_rx_en = 0;
        cyc();
        chk("R4 mid-init enable no early active", {31'd0, status[0]}, 32'd0);
        cyc();
        chk("R4 mid-init enable timing unchanged", {31'd0, status[0]}, 32'd1);

        // R5 abort mid-init
        cmd_rx_rst = 1;
        cyc();
        cmd_rx_rst = 0;
        cmd_rx_en = 1;
        cyc();
        cmd_rx_en = 0;
        cyc();
        cmd_rx_rst = 1;
        cyc();
        cmd_rx_rst = 0;
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                cyc();
                if (status[0]) seen++;
            end
            chk("R5 aborted init never activates", seen, 0);
        end
        rx_enable_and_wait("after abort");

        // R6 transmit
        cmd_tx_en = 1;
        cyc();
        cmd_tx_en = 0;
        chk("R6 tx enable sets active", {31'd0, status[1]}, 32'd1);
        tx_halted = 1;
        cyc();
        cyc();
        tx_halted = 0;
        chk("R6 halted without disable ignored", {31'd0, status[1]}, 32'd1);
        cmd_tx_dis = 1;
        cyc();
        cmd_tx_dis = 0;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R6 active holds until halted", {31'd0, status[1]}, 32'd1);
        end
        tx_halted = 1;
        cyc();
        tx_halted = 0;
        chk("R6 clears on halted edge", {31'd0, status[1]}, 32'd0);
        chk("R8 final status word", status, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule